// File: doc/BRIEF.md
# Dual-Port Synchronous SRAM Port Model

A behavioural, synthesizable model of a two-port synchronous static RAM of 18-bit words. Each side has its own clock, address, read/write line, a pair of chip enables of opposite polarity, an enable for each of its two bytes, an output enable and a latency select. Both ports reach the whole array and can read or write on every edge of their own clock, with no ordering between the addresses they use.

The latency select picks how read data reaches the port. In flow-through mode the word is presented right after the edge that captured the address. In pipelined mode it passes through an extra output register and appears one edge later. The select is sampled on the clock like every other control, so a port can change mode from one access to the next. The tri-state output of a physical part is modelled as a data bus plus one drive flag per byte. A byte with its flag low reads as zero. The output enable is the only input that is not clocked. It blanks both flags at once, with no clock edge needed.

The word splits into an upper byte at bits 17:9 and a lower byte at bits 8:0. The chip-select state and the byte enables captured with a read travel down the pipeline together with its data, so a byte disabled for one access is blanked on exactly that access's output.

Top module: `dpsram_dual`

## Requirements
- R1: While rst_ni is low and after its release, before any read, both ports hold their drive flags at 00 and their data outputs at zero, and the latency select is taken as flow-through.
- R2: At a rising edge of a port's clock, if the port is selected and rw is low, the port writes the upper byte (bits 17:9) when ub_ni is low and the lower byte (bits 8:0) when lb_ni is low. A byte whose enable is high keeps its old contents.
- R3: A read (selected, rw high) captured at edge n with the latency select low is presented after edge n. The valid flags are {~ub_ni, ~lb_ni} from that edge, bit 1 for the upper byte.
- R4: A read captured at edge n with the latency select high at edge n+1 is presented after edge n+1, and back-to-back reads stream one word per cycle. The select sampled at each edge chooses which stage drives the output after that edge.
- R5: The address is loaded at every edge, so consecutive accesses may use any addresses in any order.
- R6: A port is selected only when ce_ni is low and ce_i is high. An access captured while it is deselected writes nothing and gives drive flags 00 where its data would appear.
- R7: A byte whose enable was high at a read's capture edge is not driven when that read reaches the output, in either latency mode.
- R8: While oe_ni is high, both drive flags are 0 and the data output is zero, with no clock edge needed. When oe_ni goes low, the pending output is driven again.
- R9: A write cycle gives drive flags 00 where its data would appear.
- R10: When both ports write the same address on the same edge, each byte written by the left port takes the left data. A read on one port on the same edge as a write to that address by the other port returns the old contents.
- R11: A data output byte whose drive flag is 0 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l_i | input | 1 | Left port clock |
| clk_r_i | input | 1 | Right port clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the output pipelines |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_ce_i | input | 1 | Left chip enable, active high |
| l_rw_i | input | 1 | Left read (1) / write (0) |
| l_ub_ni | input | 1 | Left upper byte enable, active low |
| l_lb_ni | input | 1 | Left lower byte enable, active low |
| l_oe_ni | input | 1 | Left output enable, active low, asynchronous |
| l_pipe_i | input | 1 | Left latency select: 0 flow-through, 1 pipelined |
| l_addr_i | input | AW | Left word address |
| l_wdata_i | input | 18 | Left write data |
| l_rdata_o | output | 18 | Left read data, zero in undriven bytes |
| l_rvalid_o | output | 2 | Left per-byte drive flags {upper, lower} |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_ce_i | input | 1 | Right chip enable, active high |
| r_rw_i | input | 1 | Right read (1) / write (0) |
| r_ub_ni | input | 1 | Right upper byte enable, active low |
| r_lb_ni | input | 1 | Right lower byte enable, active low |
| r_oe_ni | input | 1 | Right output enable, active low, asynchronous |
| r_pipe_i | input | 1 | Right latency select: 0 flow-through, 1 pipelined |
| r_addr_i | input | AW | Right word address |
| r_wdata_i | input | 18 | Right write data |
| r_rdata_o | output | 18 | Right read data, zero in undriven bytes |
| r_rvalid_o | output | 2 | Right per-byte drive flags {upper, lower} |

## Verification
The left port fills a 256-word array in a scrambled order with an arithmetic pattern, and the right port reads every word back in flow-through mode in a second order. The roles are then swapped, with the left port streaming pipelined reads. These sweeps separate the two latencies, cycle by cycle, and catch address aliasing and lost writes. Single-byte writes and reads, deselect under either enable, mid-cycle output-enable toggles and write cycles are then tried one at a time. Each isolates one gate on the drive flags. Same-edge writes from both ports, including a split-byte case, and a read racing a write show which port's data survives and that a racing read sees the old word.

// File: rtl/dpsram_pkg.sv
package dpsram_pkg;
  localparam int BYTE_W  = 9;
  localparam int N_BYTES = 2;
  localparam int WORD_W  = BYTE_W * N_BYTES;
  typedef logic [N_BYTES-1:0] lane_t;
  typedef logic [WORD_W-1:0]  word_t;
endpackage

// File: rtl/dpsram_array.sv
module dpsram_array
  import dpsram_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_l_i,
  input  logic          clk_r_i,
  input  logic [AW-1:0] l_addr_i,
  input  lane_t         l_wbe_i,
  input  word_t         l_wdata_i,
  output word_t         l_rdata_o,
  input  logic [AW-1:0] r_addr_i,
  input  lane_t         r_wbe_i,
  input  word_t         r_wdata_i,
  output word_t         r_rdata_o
);
  // Each port owns a bank per byte lane; a per-word flag pair records which bank is newest.
  for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] bank_l [DEPTH];
    logic [BYTE_W-1:0] bank_r [DEPTH];
    logic              tag_l  [DEPTH];
    logic              tag_r  [DEPTH];
    logic              r_yield;

    // left wins a same-edge collision on this lane
    assign r_yield = l_wbe_i[b] && (l_addr_i == r_addr_i);

    always_ff @(posedge clk_l_i) begin
      if (l_wbe_i[b]) begin
        bank_l[l_addr_i] <= l_wdata_i[b*BYTE_W +: BYTE_W];
        tag_l[l_addr_i]  <= ~tag_r[l_addr_i];
      end
    end

    always_ff @(posedge clk_r_i) begin
      if (r_wbe_i[b] && !r_yield) begin
        bank_r[r_addr_i] <= r_wdata_i[b*BYTE_W +: BYTE_W];
        tag_r[r_addr_i]  <= tag_l[r_addr_i];
      end
    end

    assign l_rdata_o[b*BYTE_W +: BYTE_W] = (tag_l[l_addr_i] != tag_r[l_addr_i])
                                           ? bank_l[l_addr_i] : bank_r[l_addr_i];
    assign r_rdata_o[b*BYTE_W +: BYTE_W] = (tag_l[r_addr_i] != tag_r[r_addr_i])
                                           ? bank_l[r_addr_i] : bank_r[r_addr_i];
  end
endmodule

// File: rtl/dpsram_port.sv
module dpsram_port
  import dpsram_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          ce_i,
  input  logic          rw_i,
  input  logic          ub_ni,
  input  logic          lb_ni,
  input  logic          oe_ni,
  input  logic          pipe_i,
  input  logic [AW-1:0] addr_i,
  input  word_t         wdata_i,
  output logic [AW-1:0] mem_addr_o,
  output lane_t         mem_wbe_o,
  output word_t         mem_wdata_o,
  input  word_t         mem_rdata_i,
  output word_t         rdata_o,
  output lane_t         rvalid_o
);
  logic  sel;
  lane_t lanes_on, rd_lanes;
  lane_t s1_vld, s2_vld, out_vld;
  word_t s1_data, s2_data, out_data;
  logic  pipe_q;

  assign sel         = !ce_ni && ce_i;
  assign lanes_on    = {!ub_ni, !lb_ni};
  assign rd_lanes    = (sel && rw_i) ? lanes_on : '0;
  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = wdata_i;
  assign mem_wbe_o   = (sel && !rw_i) ? lanes_on : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= '0;
      s1_data <= '0;
      s2_vld  <= '0;
      s2_data <= '0;
      pipe_q  <= 1'b0;
    end else begin
      s1_vld <= rd_lanes;
      if (sel && rw_i) s1_data <= mem_rdata_i;
      s2_vld  <= s1_vld;
      s2_data <= s1_data;
      pipe_q  <= pipe_i;
    end
  end

  assign out_vld  = pipe_q ? s2_vld  : s1_vld;
  assign out_data = pipe_q ? s2_data : s1_data;
  assign rvalid_o = oe_ni ? '0 : out_vld;

  for (genvar b = 0; b < N_BYTES; b++) begin : g_mask
    assign rdata_o[b*BYTE_W +: BYTE_W] = rvalid_o[b] ? out_data[b*BYTE_W +: BYTE_W] : '0;
  end

  // R6
  deselect_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel && !pipe_i) |=> (rvalid_o == '0));
  // R9
  write_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && !rw_i && !pipe_i) |=> (rvalid_o == '0));
  // R3
  flow_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pipe_i |=> (rvalid_o == ($past(rd_lanes) & {N_BYTES{!oe_ni}})));
  // R4
  pipe_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_i |=> (rvalid_o == ($past(s1_vld) & {N_BYTES{!oe_ni}})));
endmodule

// File: rtl/dpsram_dual.sv
module dpsram_dual
  import dpsram_pkg::*;
#(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_l_i,
  input  logic              clk_r_i,
  input  logic              rst_ni,
  input  logic              l_ce_ni,
  input  logic              l_ce_i,
  input  logic              l_rw_i,
  input  logic              l_ub_ni,
  input  logic              l_lb_ni,
  input  logic              l_oe_ni,
  input  logic              l_pipe_i,
  input  logic [AW-1:0]     l_addr_i,
  input  logic [WORD_W-1:0] l_wdata_i,
  output logic [WORD_W-1:0] l_rdata_o,
  output logic [1:0]        l_rvalid_o,
  input  logic              r_ce_ni,
  input  logic              r_ce_i,
  input  logic              r_rw_i,
  input  logic              r_ub_ni,
  input  logic              r_lb_ni,
  input  logic              r_oe_ni,
  input  logic              r_pipe_i,
  input  logic [AW-1:0]     r_addr_i,
  input  logic [WORD_W-1:0] r_wdata_i,
  output logic [WORD_W-1:0] r_rdata_o,
  output logic [1:0]        r_rvalid_o
);
  logic [AW-1:0] l_maddr, r_maddr;
  lane_t         l_wbe, r_wbe;
  word_t         l_mwd, r_mwd, l_mrd, r_mrd;

  dpsram_port #(.AW(AW)) i_port_l (
    .clk_i(clk_l_i), .rst_ni(rst_ni), .ce_ni(l_ce_ni), .ce_i(l_ce_i), .rw_i(l_rw_i),
    .ub_ni(l_ub_ni), .lb_ni(l_lb_ni), .oe_ni(l_oe_ni), .pipe_i(l_pipe_i),
    .addr_i(l_addr_i), .wdata_i(l_wdata_i),
    .mem_addr_o(l_maddr), .mem_wbe_o(l_wbe), .mem_wdata_o(l_mwd), .mem_rdata_i(l_mrd),
    .rdata_o(l_rdata_o), .rvalid_o(l_rvalid_o)
  );

  dpsram_port #(.AW(AW)) i_port_r (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .ce_ni(r_ce_ni), .ce_i(r_ce_i), .rw_i(r_rw_i),
    .ub_ni(r_ub_ni), .lb_ni(r_lb_ni), .oe_ni(r_oe_ni), .pipe_i(r_pipe_i),
    .addr_i(r_addr_i), .wdata_i(r_wdata_i),
    .mem_addr_o(r_maddr), .mem_wbe_o(r_wbe), .mem_wdata_o(r_mwd), .mem_rdata_i(r_mrd),
    .rdata_o(r_rdata_o), .rvalid_o(r_rvalid_o)
  );

  dpsram_array #(.DEPTH(DEPTH)) i_array (
    .clk_l_i(clk_l_i), .clk_r_i(clk_r_i),
    .l_addr_i(l_maddr), .l_wbe_i(l_wbe), .l_wdata_i(l_mwd), .l_rdata_o(l_mrd),
    .r_addr_i(r_maddr), .r_wbe_i(r_wbe), .r_wdata_i(r_mwd), .r_rdata_o(r_mrd)
  );
endmodule

// File: tb/test_dpsram_dual.sv
module test_dpsram_dual;
  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_n [2], ce [2], rw [2], ub_n [2], lb_n [2], oe_n [2], pipe [2];
  logic [AW-1:0] addr [2];
  logic [17:0] wd [2], rd [2];
  logic [1:0]  rv [2];
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dpsram_dual #(.DEPTH(DEPTH)) i_dpsram_dual (
    .clk_l_i(clk), .clk_r_i(clk), .rst_ni(rst_ni),
    .l_ce_ni(ce_n[0]), .l_ce_i(ce[0]), .l_rw_i(rw[0]), .l_ub_ni(ub_n[0]), .l_lb_ni(lb_n[0]),
    .l_oe_ni(oe_n[0]), .l_pipe_i(pipe[0]), .l_addr_i(addr[0]), .l_wdata_i(wd[0]),
    .l_rdata_o(rd[0]), .l_rvalid_o(rv[0]),
    .r_ce_ni(ce_n[1]), .r_ce_i(ce[1]), .r_rw_i(rw[1]), .r_ub_ni(ub_n[1]), .r_lb_ni(lb_n[1]),
    .r_oe_ni(oe_n[1]), .r_pipe_i(pipe[1]), .r_addr_i(addr[1]), .r_wdata_i(wd[1]),
    .r_rdata_o(rd[1]), .r_rvalid_o(rv[1])
  );

  function automatic logic [17:0] pat_f(int a);
    return 18'((a * 1031 + 'h2A5) & 'h3FFFF);
  endfunction
  function automatic logic [17:0] pat_g(int a);
    return pat_f(a) ^ 18'h2AAAA;
  endfunction

  task automatic idle(int p);
    ce_n[p] = 1'b1; ce[p] = 1'b0; rw[p] = 1'b1; ub_n[p] = 1'b1; lb_n[p] = 1'b1;
    addr[p] = '0; wd[p] = '0;
  endtask
  task automatic set_rd(int p, int a, logic u, logic l);
    ce_n[p] = 1'b0; ce[p] = 1'b1; rw[p] = 1'b1; ub_n[p] = u; lb_n[p] = l; addr[p] = AW'(a);
  endtask
  task automatic set_wr(int p, int a, logic [17:0] d, logic u, logic l);
    ce_n[p] = 1'b0; ce[p] = 1'b1; rw[p] = 1'b0; ub_n[p] = u; lb_n[p] = l;
    addr[p] = AW'(a); wd[p] = d;
  endtask
  task automatic chk(int p, logic [1:0] ev, logic [17:0] ed, string tag);
    logic [17:0] md;
    md = ed & {{9{ev[1]}}, {9{ev[0]}}};
    checks++;
    if (rv[p] !== ev || rd[p] !== md) begin
      errors++;
      $display("FAIL %s port %0d: got vld=%b data=%h, expected vld=%b data=%h",
               tag, p, rv[p], rd[p], ev, md);
    end
  endtask
  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      idle(p); oe_n[p] = 1'b0; pipe[p] = 1'b0;
    end
    repeat (3) cyc();
    chk(0, 2'b00, '0, "R1 in reset"); chk(1, 2'b00, '0, "R1 in reset");
    rst_ni = 1'b1;
    cyc();
    chk(0, 2'b00, '0, "R1 after reset"); chk(1, 2'b00, '0, "R1 after reset");

    // left fills, scrambled order (R2, R5)
    for (int i = 0; i < DEPTH; i++) begin
      set_wr(0, (i * 97) % DEPTH, pat_f((i * 97) % DEPTH), 1'b0, 1'b0);
      cyc();
    end
    idle(0);
    // right flow-through readback, other order (R3, R5)
    for (int i = 0; i < DEPTH; i++) begin
      set_rd(1, (i * 53 + 7) % DEPTH, 1'b0, 1'b0);
      cyc();
      chk(1, 2'b11, pat_f((i * 53 + 7) % DEPTH), "R3 flow sweep");
    end
    // right overwrites all
    for (int i = 0; i < DEPTH; i++) begin
      set_wr(1, i, pat_g(i), 1'b0, 1'b0);
      cyc();
    end
    idle(1);
    // left pipelined stream (R4, R5)
    pipe[0] = 1'b1;
    for (int i = 0; i <= DEPTH; i++) begin
      if (i < DEPTH) set_rd(0, (i * 29) % DEPTH, 1'b0, 1'b0);
      else idle(0);
      cyc();
      if (i == 0) chk(0, 2'b00, '0, "R4 first edge empty");
      else chk(0, 2'b11, pat_g(((i - 1) * 29) % DEPTH), "R4 pipe sweep");
    end
    cyc();
    pipe[0] = 1'b0;
    cyc();

    // byte writes (R2)
    set_wr(0, 3, 18'h3FFFF, 1'b0, 1'b1); cyc();
    set_wr(0, 4, 18'h00000, 1'b1, 1'b0); cyc();
    set_rd(0, 3, 1'b0, 1'b0); cyc();
    chk(0, 2'b11, {9'h1FF, pat_g(3)[8:0]}, "R2 upper only");
    set_rd(0, 4, 1'b0, 1'b0); cyc();
    chk(0, 2'b11, {pat_g(4)[17:9], 9'h000}, "R2 lower only");

    // read byte enables (R7, R11)
    set_rd(0, 3, 1'b1, 1'b0); cyc();
    chk(0, 2'b01, {9'h1FF, pat_g(3)[8:0]}, "R7 flow lower only");
    idle(0); cyc();
    pipe[0] = 1'b1;
    set_rd(0, 5, 1'b0, 1'b1); cyc();
    chk(0, 2'b00, '0, "R4 pipe after idle");
    set_rd(0, 6, 1'b0, 1'b0); cyc();
    chk(0, 2'b10, pat_g(5), "R7 pipe upper only");
    idle(0); cyc();
    chk(0, 2'b11, pat_g(6), "R7 pipe both");
    cyc();
    chk(0, 2'b00, '0, "R4 pipe drains");
    pipe[0] = 1'b0;

    // asynchronous output enable (R8)
    set_rd(0, 7, 1'b0, 1'b0); cyc();
    chk(0, 2'b11, pat_g(7), "R8 driven");
    #2 oe_n[0] = 1'b1; #1;
    chk(0, 2'b00, '0, "R8 oe high blanks");
    oe_n[0] = 1'b0; #1;
    chk(0, 2'b11, pat_g(7), "R8 oe low restores");

    // deselect (R6)
    set_rd(0, 7, 1'b0, 1'b0); ce_n[0] = 1'b1; cyc();
    chk(0, 2'b00, '0, "R6 ce_n high");
    set_rd(0, 7, 1'b0, 1'b0); ce[0] = 1'b0; cyc();
    chk(0, 2'b00, '0, "R6 ce low");
    set_wr(0, 8, 18'h0, 1'b0, 1'b0); ce_n[0] = 1'b1; cyc();
    set_wr(0, 8, 18'h0, 1'b0, 1'b0); ce[0] = 1'b0; cyc();
    set_rd(0, 8, 1'b0, 1'b0); cyc();
    chk(0, 2'b11, pat_g(8), "R6 deselected write ignored");

    // write cycle output (R9)
    set_wr(0, 9, 18'h12345, 1'b0, 1'b0); cyc();
    chk(0, 2'b00, '0, "R9 write not driven");
    set_rd(0, 9, 1'b0, 1'b0); cyc();
    chk(0, 2'b11, 18'h12345, "R9 write landed");

    // collisions (R10)
    set_wr(0, 10, 18'h0AAAA, 1'b0, 1'b0);
    set_wr(1, 10, 18'h15555, 1'b0, 1'b0); cyc();
    set_rd(0, 10, 1'b0, 1'b0); idle(1); cyc();
    chk(0, 2'b11, 18'h0AAAA, "R10 left wins");
    set_wr(0, 12, 18'h3FE00, 1'b0, 1'b1);
    set_wr(1, 12, 18'h00000, 1'b0, 1'b0); cyc();
    set_rd(1, 12, 1'b0, 1'b0); idle(0); cyc();
    chk(1, 2'b11, 18'h3FE00, "R10 split lanes");
    set_wr(0, 11, 18'h2F0F0, 1'b0, 1'b0);
    set_rd(1, 11, 1'b0, 1'b0); cyc();
    chk(1, 2'b11, pat_g(11), "R10 racing read old");
    idle(0); set_rd(1, 11, 1'b0, 1'b0); cyc();
    chk(1, 2'b11, 18'h2F0F0, "R10 new after race");
    idle(1); cyc();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule